// File: doc/BRIEF.md
# Loop-Trace Accelerator

This block is a small coprocessor that repeatedly executes one single-path loop body. The loop body is mapped onto a fixed array of functional units arranged in rows. Every unit input has its own source multiplexer. A configuration index chooses which of the stored connection patterns drives those multiplexers, and that choice holds for the whole call.

A caller pushes a configuration word and then the live-in register values over an input stream. The block then iterates with no further input, completing one iteration per clock. The first row of units reads the output registers, which carries values from one iteration into the next. The run ends on the first iteration in which any unit marked as an exit detects its branch condition. That iteration is discarded and leaves the output registers unchanged.

The block then offers one status word. The word carries the completed iteration count and a flag that tells the caller whether the results are worth reading. When that flag is set, the four output registers follow one at a time over the output stream.

Top module: `lta_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: The first word accepted selects the configuration by bit 0 (all other bits are ignored). The next 8 accepted words load input registers 0..7 in that order, and input registers 0..3 also seed output registers 0..3. A unit operand source index 0..3 means unit 0..3 of the previous stage (for row 0, output register 0..3), and index 4..11 means input register 0..7.
- R3: Configuration 0, per iteration, with `o` the output registers and `i` the input registers:
  - Row 0 computes u0=o0+i4, u1=o1-i5, u2=o2^i6, and an exit u3 = (o2==i3).
  - Row 1 passes u0..u2 through unchanged, and has an exit u3 = (row-0 u1 == i7).
  - The new o0..o3 are the row-1 outputs, and a compare output is 1 when true, else 0.
- R4: Configuration 1, per iteration:
  - Row 0 computes u0 = o0 shifted left by i4[4:0], u1=o1&i5, u2=o2+i6, u3=o3|i7.
  - Row 1 computes u0 = pass, u1 = row-0 u1 ^ row-0 u0, u2 = pass, and an exit u3 = (row-0 u3 < row-0 u2, unsigned).
- R5: Iterations run one per clock. The first iteration in which any exit fires ends the run and does not change the output registers. The completed count is the number of iterations before it, and may be 0.
- R6: The status word holds the completed count in bits 15:0 and sets bit 31 exactly when the count exceeds 1. Bits 30:16 are 0.
- R7: The status word and each result word are held, with `out_valid` high and data stable, until `out_ready` accepts them.
- R8: When status bit 31 is set, output registers 0..3 follow the status word in order, after which the block accepts a configuration word again. When bit 31 is clear, no result words follow and the block returns at once to accepting a configuration word.
- R9: `in_ready` is 0 from the acceptance of the last operand until the block returns to accepting a configuration word, so words offered meanwhile are not consumed. `out_valid` and `in_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | Configuration word or operand |
| out_valid | output | 1 | Output stream word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Status word or result register |

## Verification
Configuration 0 is swept over decrement steps and target values so that the row-1 exit fires after 0 to several completed iterations. Separate operand sets make the row-0 exit fire on the first or second iteration, which separates the zero-count and one-count cases from the multi-iteration case and shows whether either row's exit alone can stop the run. Configuration 1 is swept over increment and threshold values, exercising the shift, AND, XOR and unsigned-compare paths. A 300-iteration run exposes counter width faults.

Further calls cover the remaining behaviour. A configuration word with all upper bits set shows that only bit 0 chooses the pattern. Calls with the consumer stalled show that output words are held. Calls with junk offered during the run show that no input is consumed while the block is busy.

// File: rtl/lta_pkg.sv
package lta_pkg;

    localparam int DATA_W  = 32;
    localparam int UNITS   = 4;
    localparam int ROWS    = 2;
    localparam int INREGS  = 8;
    localparam int CONFIGS = 2;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_CEQ  = 3'd6,
        OP_CLTU = 3'd7
    } fu_op_e;

    typedef enum logic [2:0] {
        ST_CFG  = 3'd0,
        ST_LOAD = 3'd1,
        ST_RUN  = 3'd2,
        ST_STAT = 3'd3,
        ST_RES  = 3'd4
    } ctl_state_e;

    typedef struct packed {
        fu_op_e     op;
        logic [7:0] sel_a;
        logic [7:0] sel_b;
        logic       is_exit;
    } fu_cfg_t;

    function automatic fu_cfg_t mk(input fu_op_e op, input int a, input int b, input logic ex);
        fu_cfg_t c;
        c.op      = op;
        c.sel_a   = 8'(a);
        c.sel_b   = 8'(b);
        c.is_exit = ex;
        return c;
    endfunction

    // Source index: 0..UNITS-1 previous stage, UNITS+j input register j.
    function automatic fu_cfg_t unit_setting(input int cfg, input int row, input int slot);
        fu_cfg_t c;
        c = mk(OP_OR, slot, slot, 1'b0);
        if (cfg == 0 && row == 0) begin
            case (slot)
                0: c = mk(OP_ADD, 0, 8, 1'b0);
                1: c = mk(OP_SUB, 1, 9, 1'b0);
                2: c = mk(OP_XOR, 2, 10, 1'b0);
                3: c = mk(OP_CEQ, 2, 7, 1'b1);
                default: c = mk(OP_OR, slot, slot, 1'b0);
            endcase
        end else if (cfg == 0 && row == 1) begin
            if (slot == 3) c = mk(OP_CEQ, 1, 11, 1'b1);
        end else if (cfg == 1 && row == 0) begin
            case (slot)
                0: c = mk(OP_SHL, 0, 8, 1'b0);
                1: c = mk(OP_AND, 1, 9, 1'b0);
                2: c = mk(OP_ADD, 2, 10, 1'b0);
                3: c = mk(OP_OR, 3, 11, 1'b0);
                default: c = mk(OP_OR, slot, slot, 1'b0);
            endcase
        end else if (cfg == 1 && row == 1) begin
            if (slot == 1) c = mk(OP_XOR, 1, 0, 1'b0);
            if (slot == 3) c = mk(OP_CLTU, 3, 2, 1'b1);
        end
        return c;
    endfunction

endpackage

// File: rtl/lta_fu.sv
module lta_fu
    import lta_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  fu_op_e        op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o,
    output logic          taken_o
);

    localparam int SH_W = $clog2(DW);

    always_comb begin
        y_o     = '0;
        taken_o = 1'b0;
        case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_SHL:  y_o = a_i << b_i[SH_W-1:0];
            OP_CEQ: begin
                taken_o = (a_i == b_i);
                y_o     = DW'(a_i == b_i);
            end
            OP_CLTU: begin
                taken_o = (a_i < b_i);
                y_o     = DW'(a_i < b_i);
            end
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/lta_row.sv
module lta_row
    import lta_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int NU      = UNITS,
    parameter int NIN     = INREGS,
    parameter int NCFG    = CONFIGS,
    parameter int ROW_IDX = 0,
    parameter int CFG_W   = 1
) (
    input  logic [CFG_W-1:0]       cfg_i,
    input  logic [NU-1:0][DW-1:0]  prev_i,
    input  logic [NIN-1:0][DW-1:0] regs_i,
    output logic [NU-1:0][DW-1:0]  res_o,
    output logic                   exit_o
);

    logic [NU-1:0] hit;

    for (genvar u = 0; u < NU; u++) begin : g_unit
        fu_cfg_t       cur;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] y;
        logic          taken;

        always_comb begin
            cur = unit_setting(0, ROW_IDX, u);
            for (int c = 1; c < NCFG; c++) begin
                if (int'(cfg_i) == c) cur = unit_setting(c, ROW_IDX, u);
            end
            opa = '0;
            opb = '0;
            for (int k = 0; k < NU; k++) begin
                if (int'(cur.sel_a) == k) opa = prev_i[k];
                if (int'(cur.sel_b) == k) opb = prev_i[k];
            end
            for (int k = 0; k < NIN; k++) begin
                if (int'(cur.sel_a) == NU + k) opa = regs_i[k];
                if (int'(cur.sel_b) == NU + k) opb = regs_i[k];
            end
        end

        lta_fu #(.DW(DW)) u_fu (
            .op_i   (cur.op),
            .a_i    (opa),
            .b_i    (opb),
            .y_o    (y),
            .taken_o(taken)
        );

        assign res_o[u] = y;
        assign hit[u]   = taken & cur.is_exit;
    end

    assign exit_o = |hit;

endmodule

// File: rtl/lta_top.sv
module lta_top
    import lta_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int NU    = UNITS,
    parameter int NROWS = ROWS,
    parameter int NIN   = INREGS,
    parameter int NCFG  = CONFIGS,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);

    localparam int CFG_W = (NCFG > 1) ? $clog2(NCFG) : 1;
    localparam int IDX_W = (NIN > 1) ? $clog2(NIN) : 1;
    localparam int PAD_W = DW - 1 - CNT_W;

    typedef struct packed {
        ctl_state_e               st;
        logic [CFG_W-1:0]         cfg;
        logic [IDX_W-1:0]         idx;
        logic [NIN-1:0][DW-1:0]   inr;
        logic [NU-1:0][DW-1:0]    outr;
        logic [CNT_W-1:0]         cnt;
    } ctl_t;

    ctl_t q, n;

    logic [NU-1:0][DW-1:0] stage [NROWS+1];
    logic [NROWS-1:0]      row_exit;
    logic                  exit_any;
    logic                  more;
    logic [DW-1:0]         status;

    assign stage[0] = q.outr;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        lta_row #(
            .DW     (DW),
            .NU     (NU),
            .NIN    (NIN),
            .NCFG   (NCFG),
            .ROW_IDX(r),
            .CFG_W  (CFG_W)
        ) u_row (
            .cfg_i (q.cfg),
            .prev_i(stage[r]),
            .regs_i(q.inr),
            .res_o (stage[r+1]),
            .exit_o(row_exit[r])
        );
    end

    assign exit_any = |row_exit;
    assign more     = (q.cnt > CNT_W'(1));
    assign status   = {more, {PAD_W{1'b0}}, q.cnt};

    always_comb begin
        n         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        case (q.st)
            ST_CFG: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    n.cfg = in_data[CFG_W-1:0];
                    n.idx = '0;
                    n.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    for (int k = 0; k < NIN; k++) begin
                        if (q.idx == IDX_W'(k)) n.inr[k] = in_data;
                    end
                    for (int k = 0; k < NU; k++) begin
                        if (q.idx == IDX_W'(k)) n.outr[k] = in_data;
                    end
                    if (q.idx == IDX_W'(NIN - 1)) begin
                        n.st  = ST_RUN;
                        n.cnt = '0;
                    end else begin
                        n.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (exit_any) begin
                    n.st = ST_STAT;
                end else begin
                    n.outr = stage[NROWS];
                    n.cnt  = q.cnt + 1'b1;
                end
            end
            ST_STAT: begin
                out_valid = 1'b1;
                out_data  = status;
                if (out_ready) begin
                    n.idx = '0;
                    n.st  = more ? ST_RES : ST_CFG;
                end
            end
            ST_RES: begin
                out_valid = 1'b1;
                for (int k = 0; k < NU; k++) begin
                    if (q.idx == IDX_W'(k)) out_data = q.outr[k];
                end
                if (out_ready) begin
                    if (q.idx == IDX_W'(NU - 1)) begin
                        n.st = ST_CFG;
                    end else begin
                        n.idx = q.idx + 1'b1;
                    end
                end
            end
            default: n.st = ST_CFG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

endmodule

// File: rtl/lta_checker.sv
module lta_checker
    import lta_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int NU    = UNITS,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [DW-1:0]         out_data,
    input ctl_state_e            st,
    input logic                  exit_any,
    input logic [NU-1:0][DW-1:0] outs
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    p_exit_keeps_outs_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && exit_any) |=> $stable(outs));

    p_status_fmt_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STAT) |-> ((out_data[DW-2:CNT_W] == '0) &&
                             (out_data[DW-1] == (out_data[CNT_W-1:0] > CNT_W'(1)))));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_busy_no_input_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> !in_ready);

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

endmodule

bind lta_top lta_checker #(.DW(DW), .NU(NU), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .st       (q.st),
    .exit_any (exit_any),
    .outs     (q.outr)
);

// File: tb/lta_top_bench.sv
module lta_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] iv [8];
    logic [31:0] mo [4];
    int          mn;

    always #2 clk = ~clk;

    lta_top u_lta_top (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference from R3/R4/R5.
    task automatic model(input int cfg);
        logic [31:0] o [4];
        logic [31:0] a0, a1, a2, a3, b1, b3;
        bit ex;
        for (int k = 0; k < 4; k++) o[k] = iv[k];
        mn = 0;
        for (int it = 0; it < 70000; it++) begin
            if (cfg == 0) begin
                a0 = o[0] + iv[4];
                a1 = o[1] - iv[5];
                a2 = o[2] ^ iv[6];
                b3 = {31'b0, a1 == iv[7]};
                ex = (o[2] == iv[3]) || (a1 == iv[7]);
                b1 = a1;
            end else begin
                a0 = o[0] << iv[4][4:0];
                a1 = o[1] & iv[5];
                a2 = o[2] + iv[6];
                a3 = o[3] | iv[7];
                b1 = a1 ^ a0;
                b3 = {31'b0, a3 < a2};
                ex = (a3 < a2);
            end
            if (ex) break;
            o[0] = a0; o[1] = b1; o[2] = a2; o[3] = b3;
            mn++;
        end
        for (int k = 0; k < 4; k++) mo[k] = o[k];
    endtask

    task automatic put(input logic [31:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic get(output logic [31:0] w);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        w = out_data;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic do_call(input logic [31:0] cw, input int cfg, input string tag,
                           input bit junk, input bit hold);
        logic [31:0] w, exp_st, held;
        put(cw);
        for (int k = 0; k < 8; k++) put(iv[k]);
        model(cfg);
        exp_st = {(mn > 1), 15'b0, 16'(mn)};
        if (junk) begin
            in_valid = 1'b1;
            in_data  = 32'hDEAD_BEEF;
            for (int c = 0; c < 3; c++) begin
                chk(!in_ready, "R9 in_ready while busy", {31'b0, in_ready}, 32'd0);
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
        if (hold) begin
            while (!out_valid) @(negedge clk);
            held = out_data;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk(out_valid && out_data == held, "R7 status held", out_data, held);
            end
        end
        get(w);
        chk(w == exp_st, {tag, " R5 R6 status"}, w, exp_st);
        if (mn > 1) begin
            for (int k = 0; k < 4; k++) begin
                get(w);
                chk(w == mo[k], {tag, " R8 result"}, w, mo[k]);
            end
        end
        chk(in_ready && !out_valid, "R8 back to idle", {30'b0, in_ready, out_valid}, 32'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(in_ready && !out_valid, "R1 during reset", {30'b0, in_ready, out_valid}, 32'd2);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 after reset", {30'b0, in_ready, out_valid}, 32'd2);

        // R3 basic config 0 run: 5 completed iterations
        iv = '{32'd0, 32'd10, 32'd5, 32'd99, 32'd3, 32'd1, 32'd6, 32'd4};
        do_call(32'd0, 0, "R3 R2 cfg0 basic", 1'b0, 1'b0);
        chk(mn == 5, "R3 model count", 32'(mn), 32'd5);

        // R5 row-0 exit on first iteration: zero completed
        iv = '{32'd1, 32'd2, 32'd7, 32'd7, 32'd1, 32'd1, 32'd1, 32'd1000};
        do_call(32'd0, 0, "R5 zero-iter", 1'b1, 1'b0);

        // R8 row-0 exit on second iteration: one completed, no results
        iv = '{32'd1, 32'd100, 32'd1, 32'd3, 32'd1, 32'd1, 32'd2, 32'd0};
        do_call(32'd0, 0, "R8 one-iter", 1'b0, 1'b1);

        // R6 exactly two completed sets bit 31
        iv = '{32'd4, 32'd10, 32'd0, 32'hFFFF_FFFF, 32'd2, 32'd1, 32'd0, 32'd7};
        do_call(32'd0, 0, "R6 two-iter", 1'b0, 1'b0);

        // R2 upper config bits ignored: selects config 0
        iv = '{32'd9, 32'd30, 32'h11, 32'h5555, 32'd7, 32'd2, 32'd3, 32'd20};
        do_call(32'hFFFF_FFFE, 0, "R2 cfg upper bits", 1'b0, 1'b0);

        // R4 config 1 selected by word 3, shift amount masked
        iv = '{32'd1, 32'hFF, 32'd0, 32'd0, 32'h21, 32'hF0, 32'd10, 32'd35};
        do_call(32'd3, 1, "R4 R2 cfg1 basic", 1'b1, 1'b1);

        // R6 long run: 300 completed
        iv = '{32'h8000_0001, 32'h1234, 32'd0, 32'd0, 32'd3, 32'hFFFF, 32'd1, 32'd300};
        do_call(32'd1, 1, "R6 long run", 1'b0, 1'b0);
        chk(mn == 300, "R6 model count", 32'(mn), 32'd300);

        // R3 sweep over config 0
        for (int s = 1; s <= 5; s++) begin
            for (int t = 1; t <= 4; t++) begin
                iv = '{32'd7, 32'd40, 32'h11, 32'hFFFF_0000, 32'(s + 2), 32'(s), 32'(s), 32'(40 - t * s)};
                do_call(32'd0, 0, "R3 sweep", 1'b0, 1'b0);
            end
        end

        // R4 sweep over config 1
        for (int s = 1; s <= 5; s++) begin
            for (int t = 1; t <= 4; t++) begin
                iv = '{32'd3, 32'hF0F0, 32'd0, 32'd0, 32'(s), 32'h00FF_00FF, 32'(s), 32'(t * 4)};
                do_call(32'd1, 1, "R4 sweep", 1'b0, 1'b0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule